// File: doc/BRIEF.md
# Trainable Spiking Neuron with Shift-Only Learning

This block is one spiking neuron that also learns. On each time-step strobe it takes a vector of one-bit input spikes and adds the weight of every input that spiked to half of its stored potential. The result is its drive. It emits a one-bit spike when the drive reaches a quarter of one unit. After the decision it stores the drive, less half a unit when it has fired. So a spike takes away a fixed amount of charge rather than clearing the potential.

Each input also keeps a decaying trace of its recent spikes. When training is enabled, the block compares its own spike with a one-bit teacher spike. If they disagree and the drive lies close to the threshold, each weight moves by one sixteenth of the matching trace, in the direction that reduces the error. Every scale factor is a power of two, so the datapath uses only shifts, adders and clamps, and has no multiplier. All state is signed fixed point with 12 fraction bits in a 17-bit word by default. Potential, traces and weights all appear on output ports.

Top module: `sam_neuron`

## Requirements
- R1: While `rst` is high at a clock edge, the potential and every trace are cleared to 0, `spike_out` goes to 0, and weight i is loaded from `w_init[i*W +: W]`.
- R2: At an edge where `step` is low, the potential, traces, weights and `spike_out` keep their values, whatever `x_in`, `teach` and `train` do.
- R3: At an edge with `step` high, the drive is D = clamp(sum of the weights of inputs with `x_in[i]`=1, plus potential >>> 1). `spike_out` becomes 1 when D >= 1024 (0.25) and 0 otherwise.
- R4: On the same step, the potential becomes clamp(D − 2048) if the neuron fired and D otherwise.
- R5: On a step, trace i becomes clamp((trace i >>> 1) + 4096·x_in[i]). 4096 is 1.0.
- R6: On a step with `train` high, a weight changes only when |D − 1024| < 2048 and the fired value differs from `teach`. Weight i then becomes clamp(w − (new trace i >>> 4)) if the neuron fired with teach 0, and clamp(w + (new trace i >>> 4)) if it stayed silent with teach 1. Here the new trace is the value from R5 that includes the current spike.
- R7: With `train` low, the weights do not change on a step, while the potential and traces still evolve. With `train` high, a step that falls outside the window or has a fired value equal to `teach` also leaves the weights unchanged.
- R8: Every sum is clamped to the signed W-bit range, [−65536, 65535] for W=17, instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| step | input | 1 | Time-step strobe |
| train | input | 1 | 1 enables weight learning on a step |
| x_in | input | N_IN | Input spikes |
| teach | input | 1 | Teacher spike for the current step |
| w_init | input | N_IN*W | Initial weights, packed, input i at bits i*W |
| spike_out | output | 1 | Spike decided on the last step |
| potential_out | output | W | Stored potential, signed |
| weight_out | output | N_IN*W | Current weights, packed as w_init |
| trace_out | output | N_IN*W | Current traces, packed as w_init |

## Verification
On every training step, the trace update and the weight update happen in the same cycle. The weight must use the trace that already includes this step's spike, not the stored one. The firing decision and the subtractive modulation of the potential also share that cycle. Random spike vectors, teacher bits and mode bits are applied with weights kept near the threshold, so that window hits of both signs occur often. A bench model applies the trace first, then the update, and every weight, trace and the potential are compared after each step. Directed cases drive a weight into the clamp during training and push the drive to both clamp limits.

// File: rtl/sam_pkg.sv
package sam_pkg;

   // Direction of a weight update chosen by the learning decision.
   typedef enum logic [1:0] {
      UPD_NONE = 2'd0,
      UPD_INC  = 2'd1,
      UPD_DEC  = 2'd2
   } upd_e;

   // Clamp a wide value into the signed range of a w-bit word.
   function automatic longint sat_val(longint v, int unsigned w);
      longint hi;
      longint lo;
      hi = (longint'(1) <<< (w - 1)) - 1;
      lo = -hi - 1;
      if (v > hi) return hi;
      if (v < lo) return lo;
      return v;
   endfunction

endpackage

// File: rtl/sam_trace.sv
module sam_trace
   import sam_pkg::*;
#(
   parameter int W        = 17,
   parameter int FRAC     = 12,
   parameter int DECAY_SH = 1
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                step,
   input  logic                x,
   output logic signed [W-1:0] h_q,
   output logic signed [W-1:0] h_next
);

   localparam longint ONE = longint'(1) <<< FRAC;

   longint h_wide;

   always_comb begin
      h_wide = longint'(h_q >>> DECAY_SH);
      if (x) h_wide = h_wide + ONE;
      h_next = W'(sat_val(h_wide, W));
   end

   always_ff @(posedge clk) begin
      if (rst)       h_q <= '0;
      else if (step) h_q <= h_next;
   end

endmodule

// File: rtl/sam_synapse.sv
module sam_synapse
   import sam_pkg::*;
#(
   parameter int W     = 17,
   parameter int LR_SH = 4
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                step,
   input  upd_e                upd,
   input  logic signed [W-1:0] w_init,
   input  logic signed [W-1:0] h_next,
   output logic signed [W-1:0] w_q
);

   longint delta;
   longint w_wide;
   logic signed [W-1:0] w_next;

   always_comb begin
      delta = longint'(h_next >>> LR_SH);
      unique case (upd)
         UPD_INC: w_wide = longint'(w_q) + delta;
         UPD_DEC: w_wide = longint'(w_q) - delta;
         default: w_wide = longint'(w_q);
      endcase
      w_next = W'(sat_val(w_wide, W));
   end

   always_ff @(posedge clk) begin
      if (rst)       w_q <= w_init;
      else if (step) w_q <= w_next;
   end

endmodule

// File: rtl/sam_soma.sv
module sam_soma
   import sam_pkg::*;
#(
   parameter int N_IN     = 4,
   parameter int W        = 17,
   parameter int FRAC     = 12,
   parameter int DECAY_SH = 1,
   parameter int THETA_SH = 2,
   parameter int P_SH     = 1,
   parameter int WIN_SH   = 1
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                step,
   input  logic [N_IN-1:0]     x,
   input  logic signed [W-1:0] w [N_IN],
   output logic                fire,
   output logic                in_win,
   output logic                spike_q,
   output logic signed [W-1:0] v_q
);

   localparam longint ONE   = longint'(1) <<< FRAC;
   localparam longint THETA = ONE >>> THETA_SH;
   localparam longint PDROP = ONE >>> P_SH;
   localparam longint WIN   = ONE >>> WIN_SH;

   longint acc;
   longint drive;
   longint margin;
   longint v_wide;
   logic signed [W-1:0] v_next;

   always_comb begin
      acc = longint'(v_q >>> DECAY_SH);
      for (int i = 0; i < N_IN; i++) begin
         if (x[i]) acc = acc + longint'(w[i]);
      end
      drive  = sat_val(acc, W);
      margin = drive - THETA;
      fire   = (margin >= 0);
      in_win = (margin > -WIN) && (margin < WIN);
      v_wide = fire ? (drive - PDROP) : drive;
      v_next = W'(sat_val(v_wide, W));
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         v_q     <= '0;
         spike_q <= 1'b0;
      end else if (step) begin
         v_q     <= v_next;
         spike_q <= fire;
      end
   end

endmodule

// File: rtl/sam_neuron.sv
module sam_neuron
   import sam_pkg::*;
#(
   parameter int N_IN     = 4,
   parameter int W        = 17,
   parameter int FRAC     = 12,
   parameter int DECAY_SH = 1,
   parameter int THETA_SH = 2,
   parameter int P_SH     = 1,
   parameter int WIN_SH   = 1,
   parameter int LR_SH    = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              step,
   input  logic              train,
   input  logic [N_IN-1:0]   x_in,
   input  logic              teach,
   input  logic [N_IN*W-1:0] w_init,
   output logic              spike_out,
   output logic [W-1:0]      potential_out,
   output logic [N_IN*W-1:0] weight_out,
   output logic [N_IN*W-1:0] trace_out
);

   // Elaboration-time parameter checks.
   if (N_IN < 1) begin : g_bad_nin
      $error("sam_neuron: N_IN must be at least 1");
   end
   if (W < FRAC + 3 || W > 40) begin : g_bad_w
      $error("sam_neuron: W must hold FRAC plus sign and two integer bits, and stay within 40");
   end
   if (THETA_SH > FRAC || P_SH > FRAC || WIN_SH > FRAC || LR_SH > FRAC) begin : g_bad_sh
      $error("sam_neuron: scale shifts must not exceed FRAC");
   end
   if (DECAY_SH < 1) begin : g_bad_decay
      $error("sam_neuron: decay shift must be at least 1");
   end

   logic signed [W-1:0] w_q    [N_IN];
   logic signed [W-1:0] h_q    [N_IN];
   logic signed [W-1:0] h_next [N_IN];
   logic signed [W-1:0] v_q;
   logic                fire;
   logic                in_win;
   logic                spike_q;
   upd_e                upd;

   sam_soma #(
      .N_IN(N_IN), .W(W), .FRAC(FRAC), .DECAY_SH(DECAY_SH),
      .THETA_SH(THETA_SH), .P_SH(P_SH), .WIN_SH(WIN_SH)
   ) u_soma (
      .clk(clk), .rst(rst), .step(step), .x(x_in), .w(w_q),
      .fire(fire), .in_win(in_win), .spike_q(spike_q), .v_q(v_q)
   );

   // Learning decision: sign of (fired - teacher), gated by the window.
   always_comb begin
      upd = UPD_NONE;
      if (train && in_win) begin
         if (fire && !teach)      upd = UPD_DEC;
         else if (!fire && teach) upd = UPD_INC;
      end
   end

   for (genvar i = 0; i < N_IN; i++) begin : g_in
      sam_trace #(
         .W(W), .FRAC(FRAC), .DECAY_SH(DECAY_SH)
      ) u_trace (
         .clk(clk), .rst(rst), .step(step), .x(x_in[i]),
         .h_q(h_q[i]), .h_next(h_next[i])
      );

      sam_synapse #(
         .W(W), .LR_SH(LR_SH)
      ) u_syn (
         .clk(clk), .rst(rst), .step(step), .upd(upd),
         .w_init(w_init[i*W +: W]), .h_next(h_next[i]), .w_q(w_q[i])
      );

      assign weight_out[i*W +: W] = w_q[i];
      assign trace_out[i*W +: W]  = h_q[i];
   end

   assign spike_out     = spike_q;
   assign potential_out = v_q;

endmodule

// File: rtl/sam_neuron_chk.sv
module sam_neuron_chk #(
   parameter int N_IN     = 4,
   parameter int W        = 17,
   parameter int FRAC     = 12,
   parameter int THETA_SH = 2,
   parameter int P_SH     = 1,
   parameter int LR_SH    = 4
) (
   input logic              clk,
   input logic              rst,
   input logic              step,
   input logic              train,
   input logic [N_IN-1:0]   x_in,
   input logic              spike_out,
   input logic [W-1:0]      potential_out,
   input logic [N_IN*W-1:0] weight_out,
   input logic [N_IN*W-1:0] trace_out
);

   localparam int ONE      = 1 << FRAC;
   localparam int THETA    = ONE >> THETA_SH;
   localparam int PDROP    = ONE >> P_SH;
   localparam int STEP_MAX = (2 * ONE) >> LR_SH;

   // R2: without a strobe nothing moves
   p_hold_r2: assert property (@(posedge clk) disable iff (rst)
      !step |=> ($stable(potential_out) && $stable(spike_out) &&
                 $stable(weight_out) && $stable(trace_out)));

   // R3: a silent step leaves the potential below threshold
   p_silent_ceiling_r3: assert property (@(posedge clk) disable iff (rst)
      step |=> (spike_out || ($signed(potential_out) < THETA)));

   // R4: a firing step leaves at least threshold minus the fixed drop
   p_fire_floor_r4: assert property (@(posedge clk) disable iff (rst)
      step |=> (!spike_out || ($signed(potential_out) >= THETA - PDROP)));

   // R7: weights frozen in inference mode
   p_frozen_r7: assert property (@(posedge clk) disable iff (rst)
      !train |=> $stable(weight_out));

   for (genvar i = 0; i < N_IN; i++) begin : g_chk
      // R5: an input spike seeds its trace with at least one unit
      p_trace_seed_r5: assert property (@(posedge clk) disable iff (rst)
         (step && x_in[i]) |=> ($signed(trace_out[i*W +: W]) >= ONE));

      // R6: one learning step moves a weight by a bounded amount
      p_step_bound_r6: assert property (@(posedge clk) disable iff (rst)
         (step && train) |=>
            (($signed(weight_out[i*W +: W]) - $signed($past(weight_out[i*W +: W])) <= STEP_MAX) &&
             ($signed(weight_out[i*W +: W]) - $signed($past(weight_out[i*W +: W])) >= -STEP_MAX)));
   end

endmodule

bind sam_neuron sam_neuron_chk #(
   .N_IN(N_IN), .W(W), .FRAC(FRAC), .THETA_SH(THETA_SH), .P_SH(P_SH), .LR_SH(LR_SH)
) u_chk (
   .clk(clk), .rst(rst), .step(step), .train(train), .x_in(x_in),
   .spike_out(spike_out), .potential_out(potential_out),
   .weight_out(weight_out), .trace_out(trace_out)
);

// File: tb/sim_sam_neuron.sv
module sim_sam_neuron;

   localparam int N = 4;
   localparam int W = 17;
   localparam int HI = (1 <<< (W - 1)) - 1;
   localparam int LO = -HI - 1;

   logic            clk = 1'b0;
   logic            rst = 1'b1;
   logic            step = 1'b0;
   logic            train = 1'b0;
   logic [N-1:0]    x_in = '0;
   logic            teach = 1'b0;
   logic [N*W-1:0]  w_init = '0;
   logic            spike_out;
   logic [W-1:0]    potential_out;
   logic [N*W-1:0]  weight_out;
   logic [N*W-1:0]  trace_out;

   int tests = 0;
   int fails = 0;
   bit done  = 1'b0;

   int mw [N];
   int mh [N];
   int mv;
   bit ms;

   always #10 clk = ~clk;   // 50 MHz

   sam_neuron #(.N_IN(N), .W(W)) u0 (
      .clk(clk), .rst(rst), .step(step), .train(train), .x_in(x_in),
      .teach(teach), .w_init(w_init), .spike_out(spike_out),
      .potential_out(potential_out), .weight_out(weight_out),
      .trace_out(trace_out)
   );

   function automatic int clampw(longint v);
      if (v > HI) return HI;
      if (v < LO) return LO;
      return int'(v);
   endfunction

   task automatic check(string tag, string what, int act, int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   task automatic compare_all(string tag_v, string tag_h, string tag_w);
      check(tag_v, "spike", int'(spike_out), int'(ms));
      check(tag_v, "potential", int'($signed(potential_out)), mv);
      for (int i = 0; i < N; i++) begin
         check(tag_h, $sformatf("trace%0d", i), int'($signed(trace_out[i*W +: W])), mh[i]);
         check(tag_w, $sformatf("weight%0d", i), int'($signed(weight_out[i*W +: W])), mw[i]);
      end
   endtask

   // Apply a reset with the given initial weights and check R1.
   task automatic do_reset(int w0, int w1, int w2, int w3);
      int iw [N];
      iw[0] = w0; iw[1] = w1; iw[2] = w2; iw[3] = w3;
      @(negedge clk);
      rst = 1'b1;
      step = 1'b0;
      for (int i = 0; i < N; i++) w_init[i*W +: W] = W'(iw[i]);
      @(negedge clk);
      rst = 1'b0;
      for (int i = 0; i < N; i++) begin
         mw[i] = iw[i];
         mh[i] = 0;
      end
      mv = 0;
      ms = 1'b0;
      compare_all("R1", "R1", "R1");
   endtask

   // One strobed step; the model follows R3..R8.
   task automatic do_step(logic [N-1:0] x, bit t, bit tr, string sat_tag);
      longint acc;
      int d;
      bit f;
      bit win;
      int hn [N];
      string tv, th, tw;
      @(negedge clk);
      x_in = x; teach = t; train = tr; step = 1'b1;
      acc = longint'(mv >>> 1);
      for (int i = 0; i < N; i++) if (x[i]) acc += longint'(mw[i]);
      d   = clampw(acc);
      f   = (d >= 1024);
      win = ((d - 1024) > -2048) && ((d - 1024) < 2048);
      for (int i = 0; i < N; i++) hn[i] = clampw(longint'(mh[i] >>> 1) + (x[i] ? 4096 : 0));
      if (tr && win && (f != t)) begin
         for (int i = 0; i < N; i++)
            mw[i] = f ? clampw(longint'(mw[i]) - (hn[i] >>> 4))
                      : clampw(longint'(mw[i]) + (hn[i] >>> 4));
      end
      mv = clampw(f ? longint'(d) - 2048 : longint'(d));
      ms = f;
      for (int i = 0; i < N; i++) mh[i] = hn[i];
      @(negedge clk);
      step = 1'b0;
      tv = (sat_tag != "") ? sat_tag : "R3/R4";
      th = (sat_tag != "") ? sat_tag : "R5";
      tw = (sat_tag != "") ? sat_tag : (tr ? "R6" : "R7");
      compare_all(tv, th, tw);
   endtask

   // Idle cycles with busy inputs: nothing may change (R2).
   task automatic idle_check(int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         x_in = N'($urandom); teach = 1'($urandom); train = 1'($urandom);
         @(negedge clk);
         compare_all("R2", "R2", "R2");
      end
   endtask

   function automatic int rnd_w(int span);
      return int'($urandom_range(2 * span)) - span;
   endfunction

   initial begin
      void'($urandom(32'd20211));
      repeat (3) @(negedge clk);

      // Directed: simple firing and subtractive drop (R3, R4, R5, R7).
      do_reset(1500, 200, -300, 0);
      do_step(4'b0001, 1'b0, 1'b0, "");   // drive 1500 -> fires, V=-548
      do_step(4'b0110, 1'b0, 1'b0, "");   // -100 - 274 -> silent
      idle_check(3);

      // Directed: training in both directions (R6) and no-change cases (R7).
      do_reset(1100, 0, 0, 0);
      do_step(4'b0001, 1'b0, 1'b1, "R6"); // fires, teach 0 -> decrease
      do_step(4'b0001, 1'b1, 1'b1, "R6"); // silent with teach 1 -> increase
      do_step(4'b0001, 1'b1, 1'b1, "R7"); // fired==teach or outside -> model decides
      do_reset(0, 0, 0, 0);
      do_step(4'b0000, 1'b0, 1'b1, "R7"); // silent, teach 0 -> no change

      // Directed: weight clamp while learning (R8).
      do_reset(65530, -65000, 0, 0);
      do_step(4'b0011, 1'b1, 1'b1, "R8");
      do_step(4'b0011, 1'b1, 1'b1, "R8");

      // Directed: drive clamps at both limits (R8).
      do_reset(HI, HI, HI, HI);
      do_step(4'b1111, 1'b0, 1'b0, "R8");
      do_step(4'b1111, 1'b0, 1'b0, "R8");
      do_reset(LO, LO, LO, LO);
      do_step(4'b1111, 1'b1, 1'b0, "R8");
      do_step(4'b1111, 1'b1, 1'b0, "R8");

      // Random: weights near the threshold, mixed modes.
      for (int blk = 0; blk < 8; blk++) begin
         do_reset(rnd_w(2500), rnd_w(2500), rnd_w(2500), rnd_w(2500));
         for (int s = 0; s < 40; s++) begin
            do_step(N'($urandom), 1'($urandom), ($urandom_range(9) < 7), "");
            if ($urandom_range(9) == 0) idle_check(1);
         end
      end

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (60000) @(posedge clk);
      if (!done) begin
         tests++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

endmodule